// File: doc/BRIEF.md
# Speculative Register File with Undo History

This block holds the newest, most speculative value of every logical register. The array is indexed by register number. Each accepted pipeline write first reads the value it is about to replace. It then pushes that old value, the register number and the writer's sequence tag into a circular history queue, and stores the new value in the array. Whenever an instruction commits, the pipeline frees the oldest history entry.

When a branch turns out to be mispredicted, the pipeline presents the branch's sequence tag on the flush input. The block then walks the history from the newest entry backwards. Each cycle it restores one saved value into the array, and it stops at the first entry that is not younger than the branch. Because the walk runs backwards, the oldest saved value for a register is written last. That register is left holding the value it had before any wrong-path write.

The block raises a busy output while the walk runs. During that time reads are flagged invalid and writes are refused. A full history also refuses writes until a commit frees an entry.

Top module: `ffile_histbuf`

## Requirements
- R1: After reset every register reads 0, `busy` and `wr_stall` are 0, `rd_ok` is 1, and the history is empty.
- R2: A write is accepted when `wr_en` is 1 and `wr_stall` is 0 and `flush_en` is 0. The new value is returned on `rd_data` for that register from the cycle after the accepting edge.
- R3: `commit_en` frees the oldest history entry. With an empty history it has no effect on the occupancy.
- R4: After a flush with branch tag B, every history entry younger than B is undone, newest first, one per cycle. Each touched register ends with the value it held before its oldest younger write. Older entries and all other registers are unchanged.
- R5: `busy` rises on the edge that takes `flush_en` and stays high for N+1 cycles, where N is the number of entries undone. While `busy` is high, `rd_ok` is 0 and `wr_stall` is 1.
- R6: `wr_stall` is 1 whenever the history holds its full depth of entries. A write in that state is refused even when a commit arrives in the same cycle.
- R7: A commit and an accepted write in the same cycle are both performed, and the occupancy is unchanged.
- R8: An entry with tag T is younger than branch tag B when (T - B) modulo 2^TAG_W is nonzero and below 2^(TAG_W-1). This keeps the comparison valid across tag wraparound.
- R9: A write presented in the same cycle as `flush_en` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | REG_AW | Register number to read |
| rd_data | output | DATA_W | Current speculative value of `rd_addr` |
| rd_ok | output | 1 | Read value is usable (not restoring) |
| wr_en | input | 1 | Speculative write request |
| wr_addr | input | REG_AW | Register number to write |
| wr_data | input | DATA_W | Value to write |
| wr_tag | input | TAG_W | Sequence tag of the writing instruction |
| wr_stall | output | 1 | Write refused this cycle (full or restoring) |
| commit_en | input | 1 | Oldest in-flight writer has committed |
| flush_en | input | 1 | Branch misprediction, start undo |
| flush_tag | input | TAG_W | Sequence tag of the mispredicted branch |
| busy | output | 1 | Undo walk in progress |

## Verification
A corrupted pointer or occupancy counter shows at the ports either as a wrong `wr_stall` at the fill boundary or as a wrong register value after the next flush. The fill case shows it within one write. The flush case shows it only after the walk finishes, since the walk then undoes too many or too few entries. The bench therefore fills the queue exactly, mixes same-cycle commit and write, and compares every register after each flush. It also counts the busy cycles, so a walk that stops early or overruns shows up as a length mismatch before any register value is read.

// File: rtl/ffhb_pkg.sv
package ffhb_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_UNDO = 1'b1
    } mode_e;
endpackage

// File: rtl/ffhb_regfile.sv
module ffhb_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra0,
    output logic [DW-1:0] rd0,
    input  logic [AW-1:0] ra1,
    output logic [DW-1:0] rd1
);
    logic [DW-1:0] mem_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rd0 = mem_q[ra0];
    assign rd1 = mem_q[ra1];
endmodule

// File: rtl/ffhb_histq.sv
module ffhb_histq #(
    parameter int DEPTH = 8,
    parameter int EW    = 44,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);
    logic [EW-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slot_q[waddr] <= wdata;
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/ffile_histbuf.sv
module ffile_histbuf
    import ffhb_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int HB_DEPTH = 8,
    parameter int TAG_W    = 8,
    localparam int REG_AW  = $clog2(NUM_REGS),
    localparam int HB_AW   = $clog2(HB_DEPTH),
    localparam int CNT_W   = $clog2(HB_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ok,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              wr_stall,
    input  logic              commit_en,
    input  logic              flush_en,
    input  logic [TAG_W-1:0]  flush_tag,
    output logic              busy
);
    typedef struct packed {
        logic [REG_AW-1:0] rnum;
        logic [DATA_W-1:0] old;
        logic [TAG_W-1:0]  tag;
    } hb_ent_t;

    localparam int ENT_W = $bits(hb_ent_t);

    typedef struct packed {
        mode_e             mode;
        logic [HB_AW-1:0]  tail;
        logic [CNT_W-1:0]  cnt;
        logic [TAG_W-1:0]  btag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              rf_we;
    logic [REG_AW-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] old_val;
    logic [ENT_W-1:0]  hb_rdata;
    hb_ent_t           hb_top;
    hb_ent_t           hb_new;
    logic [HB_AW-1:0]  top_idx;
    logic [TAG_W-1:0]  age;
    logic              younger;
    logic              full;
    logic              push;
    logic              pop;
    logic              undo_wr;

    assign hb_top = hb_ent_t'(hb_rdata);
    assign hb_new = '{rnum: wr_addr, old: old_val, tag: wr_tag};

    always_comb begin
        ctl_d   = ctl_q;
        top_idx = (ctl_q.tail == '0) ? HB_AW'(HB_DEPTH - 1) : ctl_q.tail - HB_AW'(1);
        age     = hb_top.tag - ctl_q.btag;
        younger = (ctl_q.cnt != '0) && (age != '0) && !age[TAG_W-1];
        full    = (ctl_q.cnt == CNT_W'(HB_DEPTH));
        push    = 1'b0;
        pop     = 1'b0;
        undo_wr = 1'b0;

        if (ctl_q.mode == MODE_RUN) begin
            push = wr_en && !full && !flush_en;
            pop  = commit_en && (ctl_q.cnt != '0) && !flush_en;
            if (flush_en) begin
                ctl_d.mode = MODE_UNDO;
                ctl_d.btag = flush_tag;
            end
            if (push) begin
                ctl_d.tail = (ctl_q.tail == HB_AW'(HB_DEPTH - 1)) ? '0
                                                                 : ctl_q.tail + HB_AW'(1);
            end
            case ({push, pop})
                2'b10:   ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                2'b01:   ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                default: ctl_d.cnt = ctl_q.cnt;
            endcase
        end else begin
            if (younger) begin
                undo_wr    = 1'b1;
                ctl_d.tail = top_idx;
                ctl_d.cnt  = ctl_q.cnt - CNT_W'(1);
            end else begin
                ctl_d.mode = MODE_RUN;
            end
        end

        rf_we    = push | undo_wr;
        rf_waddr = undo_wr ? hb_top.rnum : wr_addr;
        rf_wdata = undo_wr ? hb_top.old  : wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{mode: MODE_RUN, tail: '0, cnt: '0, btag: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ffhb_regfile #(
        .NREG (NUM_REGS),
        .DW   (DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra0   (rd_addr),
        .rd0   (rd_data),
        .ra1   (wr_addr),
        .rd1   (old_val)
    );

    ffhb_histq #(
        .DEPTH (HB_DEPTH),
        .EW    (ENT_W)
    ) u_hist (
        .clk   (clk),
        .we    (push),
        .waddr (ctl_q.tail),
        .wdata (hb_new),
        .raddr (top_idx),
        .rdata (hb_rdata)
    );

    assign busy     = (ctl_q.mode == MODE_UNDO);
    assign rd_ok    = !busy;
    assign wr_stall = busy | full;
endmodule

// File: rtl/ffhb_chk.sv
module ffhb_chk #(
    parameter int HB_DEPTH = 8,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_stall,
    input logic             commit_en,
    input logic             flush_en,
    input logic             busy,
    input logic [CNT_W-1:0] cnt
);
    a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(HB_DEPTH));

    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_stall && !flush_en && !commit_en)
        |=> cnt == $past(cnt) + CNT_W'(1));

    a_r3_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !busy && !flush_en && cnt != '0 && !(wr_en && !wr_stall))
        |=> cnt == $past(cnt) - CNT_W'(1));

    a_r4_undo_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cnt <= $past(cnt));

    a_r5_busy_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && !busy) |=> busy);

    a_r5_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wr_stall);

    a_r6_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(HB_DEPTH)) |-> wr_stall);

    a_r7_commit_and_push: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && cnt != '0 && wr_en && !wr_stall && !flush_en) |=> $stable(cnt));
endmodule

bind ffile_histbuf ffhb_chk #(
    .HB_DEPTH (HB_DEPTH),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_stall  (wr_stall),
    .commit_en (commit_en),
    .flush_en  (flush_en),
    .busy      (busy),
    .cnt       (ctl_q.cnt)
);

// File: tb/sim_ffile_histbuf.sv
module sim_ffile_histbuf;
    localparam int NR = 16;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_ok;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  wr_tag = '0;
    logic        wr_stall;
    logic        commit_en = 1'b0;
    logic        flush_en = 1'b0;
    logic [7:0]  flush_tag = '0;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ffile_histbuf u0 (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_tag(wr_tag),
        .wr_stall(wr_stall), .commit_en(commit_en), .flush_en(flush_en),
        .flush_tag(flush_tag), .busy(busy)
    );

    // reference model
    logic [31:0] mreg [NR];
    int          hreg [$];
    logic [31:0] hold [$];
    logic [7:0]  htag [$];

    // scoreboard queues: kind 0 rd_data, 1 busy, 2 wr_stall, 3 rd_ok
    int          kq [$];
    logic [31:0] eq [$];
    string       rq [$];

    function automatic bit younger(logic [7:0] t, logic [7:0] b);
        logic [7:0] d;
        d = t - b;
        return (d != 8'd0) && !d[7];
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        while (kq.size() > 0) begin
            int k;
            logic [31:0] e, a;
            string r;
            k = kq.pop_front();
            e = eq.pop_front();
            r = rq.pop_front();
            case (k)
                0: a = rd_data;
                1: a = {31'd0, busy};
                2: a = {31'd0, wr_stall};
                default: a = {31'd0, rd_ok};
            endcase
            n_chk++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, a, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
            report();
        end
    end

    task automatic expect_sig(int kind, int addr, logic [31:0] exp, string req);
        rd_addr = addr[3:0];
        kq.push_back(kind);
        eq.push_back(exp);
        rq.push_back(req);
        @(negedge clk);
        #1;
    endtask

    task automatic check_now(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_all(string req);
        for (int i = 0; i < NR; i++) expect_sig(0, i, mreg[i], req);
    endtask

    // one cycle of write and/or commit, model updated from the requirements
    task automatic step(bit w, int addr, logic [31:0] data, logic [7:0] tag, bit cm);
        bit acc;
        @(posedge clk); #1;
        wr_en = w; wr_addr = addr[3:0]; wr_data = data; wr_tag = tag; commit_en = cm;
        acc = w && (hreg.size() < DEPTH);
        @(posedge clk); #1;
        wr_en = 1'b0; commit_en = 1'b0;
        if (cm && hreg.size() > 0) begin
            void'(hreg.pop_front()); void'(hold.pop_front()); void'(htag.pop_front());
        end
        if (acc) begin
            hreg.push_back(addr); hold.push_back(mreg[addr]); htag.push_back(tag);
            mreg[addr] = data;
        end
    endtask

    // flush, optionally with a simultaneous write that must be dropped (R9)
    task automatic flush(logic [7:0] btag, bit w, int addr, logic [31:0] data, string req);
        int n;
        int bcnt;
        n = 0;
        @(posedge clk); #1;
        flush_en = 1'b1; flush_tag = btag;
        wr_en = w; wr_addr = addr[3:0]; wr_data = data; wr_tag = 8'hEE;
        @(posedge clk); #1;
        flush_en = 1'b0; wr_en = 1'b0;
        while (hreg.size() > 0 && younger(htag[$], btag)) begin
            mreg[hreg[$]] = hold[$];
            void'(hreg.pop_back()); void'(hold.pop_back()); void'(htag.pop_back());
            n++;
        end
        expect_sig(1, 0, 32'd1, {req, " R5 busy"});
        bcnt = 1;
        while (busy) begin
            @(posedge clk); #1;
            if (busy) bcnt++;
        end
        check_now({req, " R5 busy length"}, bcnt, n + 1);
    endtask

    initial begin
        for (int i = 0; i < NR; i++) mreg[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_sig(0, 0, 32'd0, "R1 r0");
        expect_sig(0, 5, 32'd0, "R1 r5");
        expect_sig(0, 15, 32'd0, "R1 r15");
        expect_sig(1, 0, 32'd0, "R1 busy");
        expect_sig(2, 0, 32'd0, "R1 stall");
        expect_sig(3, 0, 32'd1, "R1 rd_ok");

        // R2 writes
        step(1, 1, 32'hA1, 8'd1, 0);
        step(1, 2, 32'hB2, 8'd2, 0);
        step(1, 1, 32'hC3, 8'd3, 0);
        step(1, 3, 32'hD4, 8'd4, 0);
        expect_sig(0, 1, 32'hC3, "R2 r1 latest");
        expect_sig(0, 2, 32'hB2, "R2 r2");
        expect_sig(0, 3, 32'hD4, "R2 r3");

        // R4/R5/R9 flush behind tag 2, with a dropped write to r2
        @(posedge clk); #1;
        flush_en = 1'b1; flush_tag = 8'd2;
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = 32'hFFFF; wr_tag = 8'd5;
        @(posedge clk); #1;
        flush_en = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 2; i++) begin
            mreg[hreg[$]] = hold[$];
            void'(hreg.pop_back()); void'(hold.pop_back()); void'(htag.pop_back());
        end
        rd_addr = 4'd1;
        kq.push_back(3); eq.push_back(32'd0); rq.push_back("R5 rd_ok low");
        kq.push_back(2); eq.push_back(32'd1); rq.push_back("R5 stall high");
        kq.push_back(1); eq.push_back(32'd1); rq.push_back("R5 busy high");
        @(negedge clk); #1;
        begin
            int bc;
            bc = 1;
            while (busy) begin
                @(posedge clk); #1;
                if (busy) bc++;
            end
            check_now("R5 busy length", bc, 3);
        end
        expect_sig(0, 1, 32'hA1, "R4 r1 restored");
        expect_sig(0, 3, 32'h0, "R4 r3 restored");
        expect_sig(0, 2, 32'hB2, "R9 r2 write in flush cycle dropped");
        expect_sig(3, 0, 32'd1, "R5 rd_ok back");

        // R3 commit frees, extra commit on empty has no effect
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);

        // R6 fill exactly to depth
        step(1, 4, 32'h410, 8'd10, 0);
        step(1, 5, 32'h511, 8'd11, 0);
        step(1, 4, 32'h412, 8'd12, 0);
        step(1, 6, 32'h613, 8'd13, 0);
        step(1, 7, 32'h714, 8'd14, 0);
        step(1, 5, 32'h515, 8'd15, 0);
        expect_sig(2, 0, 32'd0, "R3 not full after empty commit");
        step(1, 8, 32'h816, 8'd16, 0);
        step(1, 4, 32'h417, 8'd17, 0);
        expect_sig(2, 0, 32'd1, "R6 stall at depth");
        step(1, 9, 32'h999, 8'd18, 1);
        expect_sig(0, 9, 32'h0, "R6 write refused when full");
        expect_sig(2, 0, 32'd0, "R3 commit freed one");
        step(1, 9, 32'h918, 8'd18, 1);
        expect_sig(0, 9, 32'h918, "R7 write with commit");
        expect_sig(2, 0, 32'd0, "R7 occupancy unchanged");
        step(1, 10, 32'hA19, 8'd19, 0);
        expect_sig(2, 0, 32'd1, "R7 full again after one push");

        // R4 deep undo behind tag 13
        flush(8'd13, 0, 0, 0, "R4 deep");
        expect_all("R4 all regs after deep undo");

        // R8 wraparound tags
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(1, 11, 32'hB250, 8'd250, 0);
        step(1, 12, 32'hC254, 8'd254, 0);
        step(1, 11, 32'hB002, 8'd2, 0);
        step(1, 12, 32'hC003, 8'd3, 0);
        flush(8'd253, 0, 0, 0, "R8 wrap");
        expect_sig(0, 11, 32'hB250, "R8 r11 keeps older than branch");
        expect_sig(0, 12, 32'h0, "R8 r12 restored across wrap");

        // R5 flush with nothing younger, plus a dropped write (R9)
        flush(8'd3, 1, 13, 32'hDEAD, "R5 empty walk");
        expect_sig(0, 11, 32'hB250, "R4 older entry untouched");
        expect_sig(0, 13, 32'h0, "R9 write dropped");

        report();
    end
endmodule